// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates among a parameterized set of interrupt nodes and presents the CPU with the number of the one node it should service next. Each node owns a small control word that holds a pending flag, an enable flag and a four-bit priority. A peripheral sets the pending flag with a one-cycle pulse. Software can set or clear the flag through the register port, so nodes that have no peripheral attached can still be used to raise requests.

The controller tracks the priority of the service the CPU is running. It raises a vector request only when some pending, enabled node has a priority strictly above that level. An acknowledge from the CPU accepts the current winner, clears that node's pending flag and pushes the winner's priority onto a nesting stack. A return pulse pops the stack and restores the level that was running before. The idle level is 0.

Top module: `vic_top`

## Requirements
- R1: While reset is asserted and after it, every control word reads 0, `irq_valid` is 0 and `run_level` is 0.
- R2: A control word is 6 bits: bit 5 is the pending flag, bit 4 is the enable flag and bits 3:0 are the priority. A register write replaces the whole word of node `reg_addr` on the next edge. `reg_rdata` shows the current word of node `reg_addr` combinationally.
- R3: A `hw_req` pulse on a node sets its pending flag on the next edge. This set overrides a register write that clears the flag, and it also overrides an acknowledge clear, when either happens in the same cycle.
- R4: A register write with bit 5 set makes the node pending, whether or not a peripheral drives that node.
- R5: A node is a candidate only when it is pending, is enabled and has a priority above `run_level`. `irq_valid` is 1 in the same cycle as the control state that makes a candidate exist.
- R6: The winner is the candidate with the highest priority. Among candidates of equal priority, the lowest node index wins. `irq_vector` gives the winner's index and `irq_level` gives its priority.
- R7: `irq_ack` while `irq_valid` is 1 clears the winner's pending flag, unless a `hw_req` pulse or a register write to that node comes in the same cycle. On the next edge, `run_level` becomes the winner's priority.
- R8: `irq_ack` while `irq_valid` is 0 changes neither the control words nor `run_level`.
- R9: An `irq_return` pulse restores `run_level` to the level that was running before the latest accepted acknowledge. A return with nothing nested has no effect, and a return in the same cycle as an accepted acknowledge is ignored.
- R10: A node with priority 0 is never signalled.
- R11: A pending node whose priority equals `run_level` does not preempt, so nesting can never go deeper than 15 levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | NODES | Peripheral request pulses, one per node |
| reg_wr | input | 1 | Write strobe for a control word |
| reg_addr | input | IDX_W | Node index for the write and for the readback |
| reg_wdata | input | 6 | Control word to write |
| reg_rdata | output | 6 | Control word of node `reg_addr` |
| irq_valid | output | 1 | A node beats the running level |
| irq_vector | output | IDX_W | Index of the winning node |
| irq_level | output | 4 | Priority of the winning node |
| irq_ack | input | 1 | CPU accepts the current winner |
| irq_return | input | 1 | CPU returns from the running service |
| run_level | output | 4 | Priority of the service now running |

## Verification
The bench aims at collisions in a single cycle. These include a peripheral pulse that lands together with a software clear or with the acknowledge of the same node, and an acknowledge that comes together with a return. A design that lets the clear win would drop a request. A design that honours the return would bring back the wrong level.

The bench also targets equal priorities, both between two pending nodes and between a pending node and the running level. A design with the tie-break reversed would vector to the higher index. A design with a non-strict compare would preempt itself and overflow its nesting stack.

Finally, the bench covers an acknowledge with nothing valid, a return on an empty stack and priority-0 nodes. A careless design would push a bogus level, wrap its stack pointer, or signal a node that can never run.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int PRIO_W = 4;
  localparam int CTRL_W = PRIO_W + 2;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic  pend;
    logic  ena;
    prio_t prio;
  } node_ctrl_t;
endpackage

// File: rtl/vic_node_regs.sv
module vic_node_regs import vic_pkg::*; #(
  parameter int NODES = 8,
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NODES-1:0]        hw_req,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  node_ctrl_t              wr_word,
  input  logic                    clr_en,
  input  logic [IDX_W-1:0]        clr_idx,
  output node_ctrl_t [NODES-1:0]  ctrl
);

  for (genvar g = 0; g < NODES; g++) begin : g_node
    node_ctrl_t ctrl_q;
    node_ctrl_t ctrl_d;
    logic       wr_hit;
    logic       clr_hit;
    logic       upd;

    assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(g));
    assign clr_hit = clr_en && (clr_idx == IDX_W'(g));
    assign upd     = hw_req[g] | wr_hit | clr_hit;

    // Precedence, lowest first: acknowledge clear, register write, hardware set.
    always_comb begin
      ctrl_d = ctrl_q;
      if (clr_hit)   ctrl_d.pend = 1'b0;
      if (wr_hit)    ctrl_d      = wr_word;
      if (hw_req[g]) ctrl_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctrl_q <= '0;
      else if (upd) ctrl_q <= ctrl_d;
    end

    assign ctrl[g] = ctrl_q;

    assert_hw_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hw_req[g] |=> ctrl[g].pend);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_idx == IDX_W'(g) && !hw_req[g] && !(wr_en && wr_idx == IDX_W'(g)))
      |=> !ctrl[g].pend);
  end

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter import vic_pkg::*; #(
  parameter int NODES = 8,
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  node_ctrl_t [NODES-1:0] ctrl,
  input  prio_t                  cur_level,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx,
  output prio_t                  win_prio
);

  logic [NODES-1:0] cand;

  for (genvar g = 0; g < NODES; g++) begin : g_cand
    assign cand[g] = ctrl[g].pend && ctrl[g].ena && (ctrl[g].prio > cur_level);
  end

  // Strict '>' keeps the earliest (lowest) index on ties.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < NODES; i++) begin
      if (cand[i] && (!win_valid || ctrl[i].prio > win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = ctrl[i].prio;
      end
    end
  end

endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack import vic_pkg::*; #(
  localparam int DEPTH = (1 << PRIO_W) - 1,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  prio_t push_level,
  input  logic  pop,
  output prio_t level
);

  prio_t             mem_q [DEPTH];
  logic  [PTR_W-1:0] ptr_q;
  logic  [PTR_W-1:0] ptr_d;
  logic  [PTR_W-1:0] top_idx;
  logic              pop_ok;

  assign pop_ok  = pop && !push && (ptr_q != '0);
  assign top_idx = ptr_q - 1'b1;
  assign level   = (ptr_q == '0) ? '0 : mem_q[top_idx];

  always_comb begin
    ptr_d = ptr_q;
    if (push)        ptr_d = ptr_q + 1'b1;
    else if (pop_ok) ptr_d = ptr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ptr_q <= '0;
    else if (push || pop_ok)       ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push) begin
      mem_q[ptr_q] <= push_level;
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (ptr_q < PTR_W'(DEPTH)));

  assert_push_rises_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_level > level));

  assert_pop_unwinds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && ptr_q != '0) |=> (ptr_q == $past(ptr_q) - 1'b1));

endmodule

// File: rtl/vic_top.sv
module vic_top import vic_pkg::*; #(
  parameter int NODES = 8,
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODES-1:0]  hw_req,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              irq_valid,
  output logic [IDX_W-1:0]  irq_vector,
  output logic [PRIO_W-1:0] irq_level,
  input  logic              irq_ack,
  input  logic              irq_return,
  output logic [PRIO_W-1:0] run_level
);

  node_ctrl_t [NODES-1:0] ctrl;
  logic                   accept;
  prio_t                  cur_level;

  assign accept = irq_ack && irq_valid;

  vic_node_regs #(.NODES(NODES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_req  (hw_req),
    .wr_en   (reg_wr),
    .wr_idx  (reg_addr),
    .wr_word (node_ctrl_t'(reg_wdata)),
    .clr_en  (accept),
    .clr_idx (irq_vector),
    .ctrl    (ctrl)
  );

  vic_arbiter #(.NODES(NODES)) u_arb (
    .ctrl      (ctrl),
    .cur_level (cur_level),
    .win_valid (irq_valid),
    .win_idx   (irq_vector),
    .win_prio  (irq_level)
  );

  vic_nest_stack u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (accept),
    .push_level (irq_level),
    .pop        (irq_return),
    .level      (cur_level)
  );

  assign run_level = cur_level;
  assign reg_rdata = CTRL_W'(ctrl[reg_addr]);

  assert_beats_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level > run_level));

  assert_never_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level != '0));

  assert_ack_raises_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (run_level == $past(irq_level)));

  assert_idle_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_valid && !irq_return) |=> (run_level == $past(run_level)));

endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
  localparam int NODES = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NODES-1:0] hw_req;
  logic             reg_wr;
  logic [2:0]       reg_addr;
  logic [5:0]       reg_wdata;
  logic [5:0]       reg_rdata;
  logic             irq_valid;
  logic [2:0]       irq_vector;
  logic [3:0]       irq_level;
  logic             irq_ack;
  logic             irq_return;
  logic [3:0]       run_level;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  vic_top #(.NODES(NODES)) dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
    .irq_ack(irq_ack), .irq_return(irq_return), .run_level(run_level)
  );

  // Behavioural reference model
  int m_pend [NODES];
  int m_ena  [NODES];
  int m_prio [NODES];
  int m_nest [$];

  function automatic int m_level();
    return (m_nest.size() == 0) ? 0 : m_nest[$];
  endfunction

  function automatic void m_win(output int v, output int idx, output int p);
    v = 0; idx = 0; p = 0;
    for (int i = 0; i < NODES; i++)
      if (m_pend[i] != 0 && m_ena[i] != 0 && m_prio[i] > m_level() && (v == 0 || m_prio[i] > p)) begin
        v = 1; idx = i; p = m_prio[i];
      end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) begin m_pend[i] = 0; m_ena[i] = 0; m_prio[i] = 0; end
      m_nest.delete();
    end else begin
      int v, w, p;
      bit acc;
      m_win(v, w, p);
      acc = irq_ack && v != 0;
      for (int i = 0; i < NODES; i++) begin
        if (acc && i == w) m_pend[i] = 0;
        if (reg_wr && int'(reg_addr) == i) begin
          m_pend[i] = reg_wdata[5];
          m_ena[i]  = reg_wdata[4];
          m_prio[i] = int'(reg_wdata[3:0]);
        end
        if (hw_req[i]) m_pend[i] = 1;
      end
      if (acc) m_nest.push_back(p);
      else if (irq_return && m_nest.size() > 0) void'(m_nest.pop_back());
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    int v, w, p, a;
    m_win(v, w, p);
    a = int'(reg_addr);
    check("R5 valid vs model", int'(irq_valid), v);
    if (v != 0) begin
      check("R6 vector vs model", int'(irq_vector), w);
      check("R6 level vs model", int'(irq_level), p);
    end
    check("R9 run_level vs model", int'(run_level), m_level());
    check("R2 readback vs model", int'(reg_rdata), m_pend[a] * 32 + m_ena[a] * 16 + m_prio[a]);
  endtask

  task automatic step(logic [NODES-1:0] h, bit w, int a, logic [5:0] d, bit k, bit r);
    @(negedge clk);
    compare_model();
    hw_req = h; reg_wr = w; reg_addr = 3'(a); reg_wdata = d; irq_ack = k; irq_return = r;
  endtask

  task automatic idle(int a);
    step('0, 1'b0, a, 6'h00, 1'b0, 1'b0);
    #1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hw_req = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_ack = 1'b0; irq_return = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 valid in reset", int'(irq_valid), 0);
    check("R1 run_level in reset", int'(run_level), 0);
    check("R1 word in reset", int'(reg_rdata), 0);
    rst_n = 1'b1;

    step('0, 1'b1, 2, 6'h15, 1'b0, 1'b0); idle(2);
    check("R2 readback", int'(reg_rdata), 'h15);
    check("R5 not pending", int'(irq_valid), 0);

    step(8'h04, 1'b0, 2, 6'h00, 1'b0, 1'b0); idle(2);
    check("R3 pulse sets pending", int'(irq_valid), 1);
    check("R3 vector", int'(irq_vector), 2);

    step('0, 1'b1, 6, 6'h35, 1'b0, 1'b0); idle(6);
    check("R4 software set", int'(reg_rdata), 'h35);
    check("R6 tie lowest index", int'(irq_vector), 2);

    step('0, 1'b1, 4, 6'h39, 1'b0, 1'b0); idle(4);
    check("R6 highest wins", int'(irq_vector), 4);
    check("R6 level", int'(irq_level), 9);

    step('0, 1'b0, 4, 6'h00, 1'b1, 1'b0); idle(4);
    check("R7 run_level", int'(run_level), 9);
    check("R7 pending cleared", int'(reg_rdata), 'h19);
    check("R11 lower blocked", int'(irq_valid), 0);

    step('0, 1'b1, 1, 6'h39, 1'b0, 1'b0); idle(1);
    check("R11 equal no preempt", int'(irq_valid), 0);

    step('0, 1'b0, 1, 6'h00, 1'b1, 1'b0); idle(1);
    check("R8 level kept", int'(run_level), 9);
    check("R8 word kept", int'(reg_rdata), 'h39);

    step('0, 1'b1, 0, 6'h3C, 1'b0, 1'b0); idle(0);
    check("R6 preempt vector", int'(irq_vector), 0);
    step('0, 1'b0, 0, 6'h00, 1'b1, 1'b1); idle(0);
    check("R9 return with ack ignored", int'(run_level), 12);

    step('0, 1'b0, 0, 6'h00, 1'b0, 1'b1); idle(0);
    check("R9 pop to 9", int'(run_level), 9);
    step('0, 1'b0, 0, 6'h00, 1'b0, 1'b1); idle(0);
    check("R9 pop to idle", int'(run_level), 0);
    check("R9 pending revealed", int'(irq_vector), 1);
    step('0, 1'b0, 0, 6'h00, 1'b0, 1'b1); idle(0);
    check("R9 empty return", int'(run_level), 0);

    step('0, 1'b1, 1, 6'h00, 1'b0, 1'b0);
    step('0, 1'b1, 2, 6'h00, 1'b0, 1'b0);
    step('0, 1'b1, 6, 6'h00, 1'b0, 1'b0);
    step('0, 1'b1, 3, 6'h30, 1'b0, 1'b0); idle(3);
    check("R10 prio zero silent", int'(irq_valid), 0);
    check("R10 still pending", int'(reg_rdata), 'h30);

    step(8'h20, 1'b1, 5, 6'h00, 1'b0, 1'b0); idle(5);
    check("R3 hw beats write clear", int'(reg_rdata), 'h20);

    step('0, 1'b1, 7, 6'h33, 1'b0, 1'b0); idle(7);
    check("R6 vector 7", int'(irq_vector), 7);
    step(8'h80, 1'b0, 7, 6'h00, 1'b1, 1'b0); idle(7);
    check("R7 level 3", int'(run_level), 3);
    check("R3 hw beats ack clear", int'(reg_rdata), 'h33);
    step('0, 1'b0, 7, 6'h00, 1'b0, 1'b1);

    for (int n = 0; n < 4000; n++) begin
      logic [NODES-1:0] h;
      h = ($urandom % 12 == 0) ? NODES'(1 << ($urandom % NODES)) : '0;
      step(h, ($urandom % 4) == 0, int'($urandom % NODES), 6'($urandom),
           ($urandom % 3) == 0, ($urandom % 4) == 0);
    end
    idle(0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule